// File: doc/BRIEF.md
# Shared-Line Multi-Converter Readback Sequencer

This block is a host-side master for a group of 18-bit successive-approximation converters that share one conversion-start line, one serial clock and one serial data wire. Each converter has its own active-low select line. A single `start` pulse raises the shared conversion line, so every converter samples at the same instant. The block then waits a fixed, parameterised worst-case conversion time. It cannot observe conversion progress, so the wait must cover the slowest part.

After the wait the converters are read one after another. The block pulls one select line low, which puts that device's most significant bit on the shared data wire. It then produces `DATA_W` serial clock pulses and captures one bit in each falling-edge cycle. Next it releases the select line and leaves a short gap before it selects the next device. Each finished word goes out with its channel index and a one-cycle strobe. When the last device has been read, the conversion line drops, every select line is high and `done` pulses. The serial clock idles low. Its half-period is a whole number of system clock cycles.

Top module: `adc_cs_reader`

## Requirements
- R1: In reset and afterwards until `start`: `cnv` is low, `sck` is low, every bit of `sdi_n` is 1, and `word_vld`, `done` and `busy` are 0.
- R2: A `start` sampled high in idle makes `cnv` high on that same clock edge, with all `sdi_n` bits still 1.
- R3: The first device (`sdi_n[0]`) is pulled low exactly `CONV_CYC` clock cycles after `cnv` rises.
- R4: At most one `sdi_n` bit is 0 at any time. Devices are selected in ascending index order, and only while `cnv` is high.
- R5: `sck` is low whenever no device is selected. Its first rising edge comes `SCK_HALF` cycles after a select line falls. Every high level lasts `SCK_HALF` cycles. Each device gets exactly `DATA_W` falling edges before its select line rises.
- R6: The bit on `sdo` in the cycle before each `sck` falling edge is captured. The first captured bit is bit `DATA_W-1` (MSB first), so `word` equals the device's sample.
- R7: `word_vld` is high for one cycle per device. It rises on the clock edge that makes that device's last `sck` falling edge, and `word_ch` gives the device index.
- R8: Between two devices, all `sdi_n` bits stay 1 for exactly `SCK_HALF` cycles.
- R9: On the edge of the last device's final falling edge, `cnv` drops, all `sdi_n` bits are 1 and `done` is high for one cycle.
- R10: A `start` pulse while `busy` is high is ignored. `cnv` rises only from idle, and after `done` the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one conversion and readback round |
| sdo | input | 1 | Shared serial data from the converters |
| cnv | output | 1 | Shared conversion-start line |
| sck | output | 1 | Serial clock, idles low |
| sdi_n | output | N_DEV | Per-device active-low select lines |
| word | output | DATA_W | Last completed sample |
| word_ch | output | $clog2(N_DEV) | Channel index of `word` |
| word_vld | output | 1 | One-cycle strobe for `word` |
| done | output | 1 | One-cycle strobe at the end of the round |
| busy | output | 1 | High from `start` until `done` |

## Verification
Every output in this block comes from a register, so each result is due a fixed number of cycles after the edge that causes it. `cnv` changes on the edge that samples `start`. The first select follows `CONV_CYC` edges later and the first `sck` rise `SCK_HALF` edges after that. `word_vld` and `done` land on the very edge that makes the last falling edge of a device. The bench drives inputs and samples outputs on the falling system clock. It keeps running counters from each event (conversion rise, select, release, clock rise) and compares them with these exact counts at the half-cycle where the change first shows. It also models the converters' data wire from the observed select and clock levels, so a wrong capture cycle shows up as a wrong bit in the word.

// File: rtl/adc_cs_pkg.sv
`timescale 1ns/1ps
package adc_cs_pkg;

   typedef enum logic [2:0] {
      RD_IDLE,
      RD_CONV,
      RD_SEL,
      RD_SHIFT,
      RD_GAP
   } rd_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_cs_timer.sv
`timescale 1ns/1ps
// Loadable down-counter shared by the conversion wait and the clock halves.
module adc_cs_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/adc_cs_sck.sv
`timescale 1ns/1ps
// Serial clock register: armed high on entry to the shift phase, toggled on timer ticks.
module adc_cs_sck (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic active,
   input  logic tick,
   output logic sck,
   output logic fall
);
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sck_q <= 1'b0;
      else if (arm)
         sck_q <= 1'b1;
      else if (!active)
         sck_q <= 1'b0;
      else if (tick)
         sck_q <= ~sck_q;
   end

   assign sck  = sck_q;
   assign fall = active & tick & sck_q;
endmodule

// File: rtl/adc_cs_select.sv
`timescale 1ns/1ps
// Registered one-of-N active-low select decode.
module adc_cs_select #(
   parameter int N_DEV = 2,
   parameter int CH_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_nxt,
   input  logic [CH_W-1:0]  ch_nxt,
   output logic [N_DEV-1:0] sdi_n
);
   for (genvar i = 0; i < N_DEV; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sdi_n[i] <= 1'b1;
         else
            sdi_n[i] <= !(en_nxt && (ch_nxt == CH_W'(i)));
      end
   end
endmodule

// File: rtl/adc_cs_capture.sv
`timescale 1ns/1ps
// Shift register for incoming bits and the registered word output.
module adc_cs_capture #(
   parameter int DATA_W = 18,
   parameter int CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              last,
   input  logic              sdo,
   input  logic [CH_W-1:0]   ch,
   output logic [DATA_W-1:0] word,
   output logic [CH_W-1:0]   word_ch,
   output logic              word_vld
);
   logic [DATA_W-2:0] sr;
   logic [DATA_W-1:0] nxt;

   assign nxt = {sr, sdo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr       <= '0;
         word     <= '0;
         word_ch  <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (shift_en) begin
            sr <= nxt[DATA_W-2:0];
            if (last) begin
               word     <= nxt;
               word_ch  <= ch;
               word_vld <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/adc_cs_reader.sv
`timescale 1ns/1ps
module adc_cs_reader #(
   parameter int N_DEV    = 2,
   parameter int DATA_W   = 18,
   parameter int SCK_HALF = 2,
   parameter int CONV_CYC = 16,
   localparam int CH_W    = $clog2(N_DEV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sdo,
   output logic              cnv,
   output logic              sck,
   output logic [N_DEV-1:0]  sdi_n,
   output logic [DATA_W-1:0] word,
   output logic [CH_W-1:0]   word_ch,
   output logic              word_vld,
   output logic              done,
   output logic              busy
);
   import adc_cs_pkg::*;

   localparam int TMAX = max_of(CONV_CYC, SCK_HALF);
   localparam int TW   = $clog2(TMAX + 1);
   localparam int BW   = $clog2(DATA_W + 1);
   localparam logic [TW-1:0]   HALF_LD = TW'(SCK_HALF - 1);
   localparam logic [TW-1:0]   CONV_LD = TW'(CONV_CYC - 1);
   localparam logic [BW-1:0]   LAST_BIT = BW'(DATA_W - 1);
   localparam logic [CH_W-1:0] LAST_CH  = CH_W'(N_DEV - 1);

   if (N_DEV < 2) begin : g_bad_dev
      $error("adc_cs_reader: N_DEV must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("adc_cs_reader: DATA_W must be at least 2");
   end
   if (SCK_HALF < 1) begin : g_bad_half
      $error("adc_cs_reader: SCK_HALF must be at least 1");
   end
   if (CONV_CYC < 1) begin : g_bad_conv
      $error("adc_cs_reader: CONV_CYC must be at least 1");
   end

   rd_state_t       st, st_n;
   logic            cnv_q, cnv_n;
   logic            sel_on, sel_on_n;
   logic [CH_W-1:0] ch, ch_n;
   logic [BW-1:0]   bitcnt, bitcnt_n;
   logic            done_q, done_n;
   logic            t_load, t_exp;
   logic [TW-1:0]   t_val;
   logic            sck_arm, sck_fall;

   adc_cs_timer #(.CNT_W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   adc_cs_sck u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (sck_arm),
      .active (st == RD_SHIFT),
      .tick   (t_exp),
      .sck    (sck),
      .fall   (sck_fall)
   );

   adc_cs_select #(.N_DEV(N_DEV), .CH_W(CH_W)) u_select (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_nxt (sel_on_n),
      .ch_nxt (ch_n),
      .sdi_n  (sdi_n)
   );

   adc_cs_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sck_fall),
      .last     (bitcnt == LAST_BIT),
      .sdo      (sdo),
      .ch       (ch),
      .word     (word),
      .word_ch  (word_ch),
      .word_vld (word_vld)
   );

   always_comb begin
      st_n     = st;
      cnv_n    = cnv_q;
      sel_on_n = sel_on;
      ch_n     = ch;
      bitcnt_n = bitcnt;
      done_n   = 1'b0;
      t_load   = 1'b0;
      t_val    = HALF_LD;
      sck_arm  = 1'b0;
      unique case (st)
         RD_IDLE: begin
            if (start) begin
               st_n   = RD_CONV;
               cnv_n  = 1'b1;
               t_load = 1'b1;
               t_val  = CONV_LD;
            end
         end
         RD_CONV: begin
            if (t_exp) begin
               st_n     = RD_SEL;
               sel_on_n = 1'b1;
               ch_n     = '0;
               t_load   = 1'b1;
            end
         end
         RD_SEL: begin
            if (t_exp) begin
               st_n     = RD_SHIFT;
               sck_arm  = 1'b1;
               bitcnt_n = '0;
               t_load   = 1'b1;
            end
         end
         RD_SHIFT: begin
            if (t_exp) begin
               t_load = 1'b1;
               if (sck_fall) begin
                  bitcnt_n = bitcnt + 1'b1;
                  if (bitcnt == LAST_BIT) begin
                     sel_on_n = 1'b0;
                     if (ch == LAST_CH) begin
                        st_n   = RD_IDLE;
                        cnv_n  = 1'b0;
                        done_n = 1'b1;
                     end else begin
                        st_n = RD_GAP;
                     end
                  end
               end
            end
         end
         RD_GAP: begin
            if (t_exp) begin
               st_n     = RD_SEL;
               sel_on_n = 1'b1;
               ch_n     = ch + 1'b1;
               t_load   = 1'b1;
            end
         end
         default: st_n = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         cnv_q  <= 1'b0;
         sel_on <= 1'b0;
         ch     <= '0;
         bitcnt <= '0;
         done_q <= 1'b0;
      end else begin
         st     <= st_n;
         cnv_q  <= cnv_n;
         sel_on <= sel_on_n;
         ch     <= ch_n;
         bitcnt <= bitcnt_n;
         done_q <= done_n;
      end
   end

   assign cnv  = cnv_q;
   assign done = done_q;
   assign busy = (st != RD_IDLE);
endmodule

// File: rtl/adc_cs_reader_chk.sv
`timescale 1ns/1ps
module adc_cs_reader_chk #(
   parameter int N_DEV    = 2,
   parameter int CONV_CYC = 16,
   parameter int CH_W     = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnv,
   input logic             sck,
   input logic [N_DEV-1:0] sdi_n,
   input logic [CH_W-1:0]  word_ch,
   input logic             word_vld,
   input logic             done,
   input logic             busy
);
   localparam int CW = $clog2(CONV_CYC + 1);

   logic [CW-1:0] conv_cnt;
   logic          sel_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_cnt <= '0;
         sel_seen <= 1'b0;
      end else begin
         if (!cnv)
            conv_cnt <= '0;
         else if (conv_cnt != CW'(CONV_CYC))
            conv_cnt <= conv_cnt + 1'b1;
         if (!cnv)
            sel_seen <= 1'b0;
         else if (!(&sdi_n))
            sel_seen <= 1'b1;
      end
   end

   // R2
   sel_idle_at_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv) |-> (&sdi_n));

   // R3
   conv_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(&sdi_n) && !sel_seen) |-> (conv_cnt >= CW'(CONV_CYC)));

   // R4
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sdi_n) <= 1);

   // R4
   sel_needs_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&sdi_n) |-> cnv);

   // R5
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&sdi_n) |-> !sck);

   // R7
   word_ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (int'(word_ch) < N_DEV));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cnv && (&sdi_n) && !busy));

   // R10
   rise_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv) |-> !$past(busy));
endmodule

bind adc_cs_reader adc_cs_reader_chk #(
   .N_DEV    (N_DEV),
   .CONV_CYC (CONV_CYC),
   .CH_W     (CH_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnv      (cnv),
   .sck      (sck),
   .sdi_n    (sdi_n),
   .word_ch  (word_ch),
   .word_vld (word_vld),
   .done     (done),
   .busy     (busy)
);

// File: tb/adc_cs_reader_test.sv
`timescale 1ns/1ps
module adc_cs_reader_test;
   localparam int NDEV = 3;
   localparam int DW   = 18;
   localparam int HALF = 2;
   localparam int CONV = 7;
   localparam int CHW  = $clog2(NDEV);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sdo = 1'b0;
   logic cnv, sck, word_vld, done, busy;
   logic [NDEV-1:0] sdi_n;
   logic [DW-1:0]   word;
   logic [CHW-1:0]  word_ch;

   always #2.5 clk = ~clk;

   adc_cs_reader #(.N_DEV(NDEV), .DATA_W(DW), .SCK_HALF(HALF), .CONV_CYC(CONV)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo), .cnv(cnv), .sck(sck),
      .sdi_n(sdi_n), .word(word), .word_ch(word_ch), .word_vld(word_vld),
      .done(done), .busy(busy)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;
   logic [DW-1:0] vals [NDEV];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         report();
      end
   end

   // Converter model plus timing monitor, evaluated mid-cycle.
   bit mon_on = 0;
   logic prev_cnv = 0, prev_sck = 0;
   logic [NDEV-1:0] prev_sdi = '1;
   int cnv_cnt = 0, sel_cnt = 0, hi_run = 0, gap_cnt = 0;
   int falls = 0, bitidx = -1, cur = -1, exp_dev = 0, words = 0;
   bit first_rise = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         cnv_cnt = (cnv && !prev_cnv) ? 0 : cnv_cnt + 1;
         sel_cnt++;
         gap_cnt++;
         if (sck) hi_run++;
         if (cnv && !prev_cnv) begin
            // R2: no select line low when conversion starts
            chk(&sdi_n, "R2", int'(sdi_n), (1 << NDEV) - 1);
            exp_dev = 0;
            words = 0;
         end
         if (!prev_sck && sck && first_rise) begin
            // R5: first rise SCK_HALF cycles after select
            chk(sel_cnt == HALF, "R5", sel_cnt, HALF);
            first_rise = 0;
         end
         if (prev_sck && !sck) begin
            // R5: high level width
            chk(hi_run == HALF, "R5", hi_run, HALF);
            hi_run = 0;
            falls++;
            bitidx--;
         end
         for (int d = 0; d < NDEV; d++) begin
            if (!prev_sdi[d] && sdi_n[d]) begin
               // R5: falling edges per device
               chk(falls == DW, "R5", falls, DW);
               gap_cnt = 0;
               cur = -1;
               exp_dev++;
            end
         end
         for (int d = 0; d < NDEV; d++) begin
            if (prev_sdi[d] && !sdi_n[d]) begin
               // R4: ascending order, only while cnv high
               chk(d == exp_dev && cnv, "R4", d, exp_dev);
               if (d == 0)
                  chk(cnv_cnt == CONV, "R3", cnv_cnt, CONV);
               else
                  chk(gap_cnt == HALF, "R8", gap_cnt, HALF);
               cur = d;
               bitidx = DW - 1;
               falls = 0;
               sel_cnt = 0;
               first_rise = 1;
            end
         end
         if (word_vld) begin
            chk(int'(word_ch) == words, "R7", int'(word_ch), words);
            chk(falls == DW && prev_sck && !sck, "R7", falls, DW);
            chk(word == vals[word_ch], "R6", int'(word), int'(vals[word_ch]));
            words++;
         end
         if (done) begin
            chk(!cnv && (&sdi_n), "R9", int'(cnv), 0);
            chk(words == NDEV, "R9", words, NDEV);
         end
      end
      sdo = (cur >= 0 && bitidx >= 0) ? vals[cur][bitidx] : 1'b0;
      prev_cnv = cnv;
      prev_sck = sck;
      prev_sdi = sdi_n;
   end

   task automatic run_once(input int restart_at);
      int waited = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: cnv up on the edge that sampled start
      chk(cnv && busy, "R2", int'(cnv), 1);
      while (!done && waited < 5000) begin
         @(negedge clk);
         waited++;
         start = (waited == restart_at) && !done;
      end
      start = 1'b0;
      // R9: round completes
      chk(done, "R9", int'(done), 1);
      repeat (4) @(negedge clk);
      // R10: restart during busy had no effect, block idle
      chk(!cnv && !busy, "R10", int'(cnv), 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int d = 0; d < NDEV; d++) vals[d] = '0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(!cnv && !sck && (&sdi_n) && !word_vld && !done && !busy, "R1", int'(sdi_n), (1 << NDEV) - 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!cnv && !sck && (&sdi_n) && !busy, "R1", int'(cnv), 0);
      mon_on = 1;

      // Directed patterns
      for (int d = 0; d < NDEV; d++) vals[d] = '1;
      run_once(0);
      for (int d = 0; d < NDEV; d++) vals[d] = '0;
      run_once(3);
      for (int d = 0; d < NDEV; d++) vals[d] = (d % 2 == 0) ? DW'(18'h2aaaa) : DW'(18'h15555);
      run_once(CONV + 2);
      vals[0] = DW'(1) << (DW - 1); vals[1] = DW'(1); vals[2] = '1;
      run_once(CONV + 3 * HALF * DW);

      // Random rounds
      for (int r = 0; r < 20; r++) begin
         for (int d = 0; d < NDEV; d++) vals[d] = DW'($urandom());
         run_once(int'($urandom_range(1, 150)));
      end

      report();
   end
endmodule